// File: doc/BRIEF.md
# Option ROM Signature Scanner

This block searches a fixed region of the memory map for add-in ROM images after a start pulse. It walks the region on 2 KB boundaries and reads each candidate through a synchronous byte read port with one cycle of latency. A candidate counts as an image when its first two bytes form the signature 0x55, 0xAA and its third byte, a length in 512-byte units, describes an image that lies wholly inside the region.

Each such image is then read end to end, one byte per cycle, and its 8-bit sum is taken. An image whose sum is zero is reported to the host as an entry address (base + 3). The scanner then waits for an acknowledge before it resumes at the first 2 KB boundary at or beyond the image's end. Images whose sum is nonzero are passed over and counted. When the region is exhausted the block gives a one-cycle completion pulse and goes idle.

Top module: `optrom_scanner`

## Requirements
- R1: After start, candidates are visited at every 2 KB boundary from 0xC0000 up to but not including 0xE0000. Once the next candidate would be at or beyond 0xE0000, `done` is high for exactly one cycle and the block goes idle: no reads and no reports until the next start.
- R2: A candidate passes the signature test only when the byte at base+0 equals 0x55 and the byte at base+1 equals 0xAA. Any other pair, including the swapped order, is never reported, and the next candidate is base + 2 KB.
- R3: The byte at base+2 is the image size in 512-byte units. A size of 0, or an image whose end (base + size×512) lies beyond 0xE0000, is rejected without a report and without touching `err_cnt`. The scan then continues at base + 2 KB.
- R4: For an image that passes R2 and R3, all size×512 bytes from base onward are summed modulo 256. A nonzero sum causes no report, increments `err_cnt` by one (saturating), and the scan continues at base + 2 KB.
- R5: A zero-sum image is reported by holding `found_valid` high with `entry_addr` = base + 3. Both stay unchanged, and no memory read is issued, until the cycle in which `ack` is sampled high.
- R6: After an acknowledged report, the next candidate is the image end rounded up to a multiple of 2 KB. A signature that lies inside a reported image is never reported.
- R7: `rd_data` is taken as the byte addressed by `rd_addr` in the cycle after `rd_en` is high. Every issued address lies inside the scan region, and the summing pass issues one read per cycle.
- R8: A start pulse seen while idle clears `err_cnt` and begins a scan. A start pulse during a scan is ignored, so the reports and final count are the same as without it.
- R9: While reset is high, and in the cycle after it, `found_valid`, `done`, `rd_en` and `err_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan when idle |
| ack | input | 1 | Host has taken the current report |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory byte address |
| rd_data | input | 8 | Read byte, valid one cycle after rd_en |
| found_valid | output | 1 | A verified image is being reported |
| entry_addr | output | ADDR_W | Entry address of the reported image |
| done | output | 1 | One-cycle pulse when the region is exhausted |
| err_cnt | output | CNT_W | Number of images that failed the sum check |

## Verification
The hardest case to produce from the ports is an image that passes its signature and size tests and is still rejected. Other cases are just as hard to produce: an image that ends exactly on a boundary, one that runs past the region's end, and a decoy signature buried inside a valid image. The bench memory model builds every image procedurally and computes the closing byte of each image so that the sum comes to zero. For one image it deliberately adds one to that byte. Because the expected sum depends on every byte being read on the right cycle, a read-latency slip shows up as missing reports and a wrong failure count. A stray start pulse in mid-scan, followed by a second full scan, checks that the counter clears only when the block is idle.

// File: rtl/optrom_pkg.sv
package optrom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAND,
        ST_SIG0,
        ST_SIG1,
        ST_LEN,
        ST_SUM,
        ST_TAIL,
        ST_REPORT
    } scan_state_t;

    localparam logic [7:0] SIG_FIRST  = 8'h55;
    localparam logic [7:0] SIG_SECOND = 8'hAA;
    localparam int         ENTRY_OFS  = 3;

    function automatic logic [7:0] byte_add(input logic [7:0] a, input logic [7:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/optrom_span_calc.sv
module optrom_span_calc #(
    parameter int               ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] WIN_HI   = 20'hE0000,
    parameter int               STRIDE_LG = 11,
    parameter int               UNIT_LG   = 9,
    localparam int              EXT_W     = ADDR_W + 1
) (
    input  logic [EXT_W-1:0] base,
    input  logic [7:0]       len,
    output logic [EXT_W-1:0] img_end,
    output logic             fits,
    output logic [EXT_W-1:0] next_skip,
    output logic [EXT_W-1:0] next_after
);
    localparam logic [EXT_W-1:0] STEP = EXT_W'(1) << STRIDE_LG;
    localparam logic [EXT_W-1:0] MASK = ~(STEP - EXT_W'(1));
    localparam logic [EXT_W-1:0] HI_E = {1'b0, WIN_HI};

    logic [EXT_W-1:0] span;

    always_comb begin
        span       = EXT_W'(len) << UNIT_LG;
        img_end    = base + span;
        fits       = (len != 8'd0) && (img_end <= HI_E);
        next_skip  = base + STEP;
        next_after = (img_end + STEP - EXT_W'(1)) & MASK;
    end
endmodule

// File: rtl/optrom_sum8.sv
module optrom_sum8
    import optrom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic       zero_with_din
);
    logic [7:0] sum_q;
    logic [7:0] sum_nxt;

    always_comb begin
        sum_nxt       = byte_add(sum_q, din);
        zero_with_din = (sum_nxt == 8'd0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= 8'd0;
        end else if (en) begin
            sum_q <= sum_nxt;
        end
    end
endmodule

// File: rtl/optrom_sig_det.sv
module optrom_sig_det
    import optrom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       cap_first,
    input  logic       cap_second,
    input  logic [7:0] din,
    output logic       match
);
    logic first_ok;
    logic second_ok;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            first_ok  <= 1'b0;
            second_ok <= 1'b0;
        end else begin
            if (cap_first)  first_ok  <= (din == SIG_FIRST);
            if (cap_second) second_ok <= (din == SIG_SECOND);
        end
    end

    assign match = first_ok && second_ok;
endmodule

// File: rtl/optrom_scanner.sv
module optrom_scanner
    import optrom_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] WIN_LO    = 20'hC0000,
    parameter logic [ADDR_W-1:0] WIN_HI    = 20'hE0000,
    parameter int                STRIDE_LG = 11,
    parameter int                UNIT_LG   = 9,
    parameter int                CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ack,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              found_valid,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              done,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int               EXT_W   = ADDR_W + 1;
    localparam logic [EXT_W-1:0] LO_E    = {1'b0, WIN_LO};
    localparam logic [EXT_W-1:0] HI_E    = {1'b0, WIN_HI};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    scan_state_t      state;
    logic [EXT_W-1:0] base_q;
    logic [EXT_W-1:0] ptr_q;
    logic [7:0]       len_q;
    logic             sum_pend;
    logic             found_q;
    logic [ADDR_W-1:0] entry_q;
    logic             done_q;
    logic [CNT_W-1:0] err_q;

    logic [7:0]       calc_len;
    logic [EXT_W-1:0] img_end;
    logic             img_fits;
    logic [EXT_W-1:0] next_skip;
    logic [EXT_W-1:0] next_after;
    logic [EXT_W-1:0] last_addr;
    logic             sig_match;
    logic             sum_zero;
    logic [EXT_W-1:0] addr_ext;
    logic             in_window;

    assign calc_len  = (state == ST_LEN) ? rd_data : len_q;
    assign last_addr = img_end - EXT_W'(1);
    assign in_window = (base_q < HI_E);

    optrom_span_calc #(
        .ADDR_W   (ADDR_W),
        .WIN_HI   (WIN_HI),
        .STRIDE_LG(STRIDE_LG),
        .UNIT_LG  (UNIT_LG)
    ) u_span (
        .base      (base_q),
        .len       (calc_len),
        .img_end   (img_end),
        .fits      (img_fits),
        .next_skip (next_skip),
        .next_after(next_after)
    );

    optrom_sig_det u_sig (
        .clk       (clk),
        .rst       (rst),
        .clr       (state == ST_CAND),
        .cap_first (state == ST_SIG0),
        .cap_second(state == ST_SIG1),
        .din       (rd_data),
        .match     (sig_match)
    );

    optrom_sum8 u_sum (
        .clk          (clk),
        .rst          (rst),
        .clr          (state == ST_LEN),
        .en           (((state == ST_SUM) || (state == ST_TAIL)) && sum_pend),
        .din          (rd_data),
        .zero_with_din(sum_zero)
    );

    always_comb begin
        rd_en    = 1'b0;
        addr_ext = base_q;
        unique case (state)
            ST_CAND: begin
                rd_en    = in_window;
                addr_ext = base_q;
            end
            ST_SIG0: begin
                rd_en    = 1'b1;
                addr_ext = base_q + EXT_W'(1);
            end
            ST_SIG1: begin
                rd_en    = 1'b1;
                addr_ext = base_q + EXT_W'(2);
            end
            ST_SUM: begin
                rd_en    = 1'b1;
                addr_ext = ptr_q;
            end
            default: begin
                rd_en    = 1'b0;
                addr_ext = base_q;
            end
        endcase
        rd_addr = addr_ext[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base_q   <= '0;
            ptr_q    <= '0;
            len_q    <= '0;
            sum_pend <= 1'b0;
            found_q  <= 1'b0;
            entry_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= LO_E;
                        err_q  <= '0;
                        state  <= ST_CAND;
                    end
                end
                ST_CAND: begin
                    if (in_window) begin
                        state <= ST_SIG0;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_SIG0: state <= ST_SIG1;
                ST_SIG1: state <= ST_LEN;
                ST_LEN: begin
                    len_q <= rd_data;
                    if (sig_match && img_fits) begin
                        ptr_q    <= base_q;
                        sum_pend <= 1'b0;
                        state    <= ST_SUM;
                    end else begin
                        base_q <= next_skip;
                        state  <= ST_CAND;
                    end
                end
                ST_SUM: begin
                    ptr_q    <= ptr_q + EXT_W'(1);
                    sum_pend <= 1'b1;
                    if (ptr_q == last_addr) begin
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    sum_pend <= 1'b0;
                    if (sum_zero) begin
                        found_q <= 1'b1;
                        entry_q <= ADDR_W'(base_q + EXT_W'(ENTRY_OFS));
                        state   <= ST_REPORT;
                    end else begin
                        if (err_q != CNT_MAX) err_q <= err_q + CNT_W'(1);
                        base_q <= next_skip;
                        state  <= ST_CAND;
                    end
                end
                ST_REPORT: begin
                    if (ack) begin
                        found_q <= 1'b0;
                        base_q  <= next_after;
                        state   <= ST_CAND;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign found_valid = found_q;
    assign entry_addr  = entry_q;
    assign done        = done_q;
    assign err_cnt     = err_q;
endmodule

// File: rtl/optrom_scanner_chk.sv
module optrom_scanner_chk #(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] WIN_LO    = 20'hC0000,
    parameter logic [ADDR_W-1:0] WIN_HI    = 20'hE0000,
    parameter int                STRIDE_LG = 11,
    parameter int                CNT_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              ack,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              found_valid,
    input logic [ADDR_W-1:0] entry_addr,
    input logic              done,
    input logic [CNT_W-1:0]  err_cnt
);
    assert_addr_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= WIN_LO) && (rd_addr < WIN_HI));

    assert_report_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (found_valid && !ack) |=> (found_valid && $stable(entry_addr)));

    assert_no_read_in_report_R5: assert property (@(posedge clk) disable iff (rst)
        found_valid |-> !rd_en);

    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> (!found_valid && !rd_en));

    assert_err_step_R4: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((err_cnt == $past(err_cnt)) || (err_cnt == CNT_W'($past(err_cnt) + 1'b1))));

    assert_entry_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        found_valid |-> (entry_addr[STRIDE_LG-1:0] == STRIDE_LG'(3)));
endmodule

bind optrom_scanner optrom_scanner_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_LO   (WIN_LO),
    .WIN_HI   (WIN_HI),
    .STRIDE_LG(STRIDE_LG),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ack        (ack),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .found_valid(found_valid),
    .entry_addr (entry_addr),
    .done       (done),
    .err_cnt    (err_cnt)
);

// File: tb/tb_optrom_scanner.sv
module tb_optrom_scanner;
    localparam int CLK_NS = 10;
    localparam int NIMG   = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        ack = 1'b0;
    logic        rd_en;
    logic [19:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        found_valid;
    logic [19:0] entry_addr;
    logic        done;
    logic [7:0]  err_cnt;

    always #(CLK_NS/2) clk = ~clk;

    optrom_scanner dut (
        .clk(clk), .rst(rst), .start(start), .ack(ack),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .found_valid(found_valid), .entry_addr(entry_addr),
        .done(done), .err_cnt(err_cnt)
    );

    // image layout of the memory model
    logic [19:0] ib [NIMG];
    int          isp[NIMG];
    logic [7:0]  h0 [NIMG];
    logic [7:0]  h1 [NIMG];
    logic [7:0]  h2 [NIMG];
    logic [7:0]  fx [NIMG];
    logic [7:0]  bump[NIMG];

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        logic [7:0] r;
        int off;
        r = 8'hFF;
        for (int i = 0; i < NIMG; i++) begin
            if (a >= ib[i] && int'(a - ib[i]) < isp[i]) begin
                off = int'(a - ib[i]);
                if (off == 0)                    r = h0[i];
                else if (off == 1)               r = h1[i];
                else if (off == 2)               r = h2[i];
                else if (off == isp[i] - 1)      r = fx[i];
                else if (i == 1 && off == 2048)  r = 8'h55;
                else if (i == 1 && off == 2049)  r = 8'hAA;
                else                             r = a[7:0] ^ a[15:8] ^ 8'h3C;
            end
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem_byte(rd_addr);
    end

    int total = 0;
    int bad = 0;
    int done_seen = 0;
    int rep_cnt = 0;
    int addr_bad = 0;
    int hold_bad = 0;
    int exp_err = 0;
    logic [19:0] exp_q[$];
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // driver: load the expected reports of one scan, then pulse start
    task automatic run_scan(input bit stray_start);
        exp_q.push_back(20'hC0003);   // R2 plain image, end aligned
        exp_q.push_back(20'hC1003);   // R6 decoy at C1800 must be skipped
        exp_q.push_back(20'hDF003);   // last image that fits the window
        exp_err = 1;                  // R3/R4 only the bad-sum image counts
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (stray_start) begin
            repeat (300) @(negedge clk);
            start = 1'b1;             // R8 ignored mid-scan
            @(negedge clk) start = 1'b0;
        end
    endtask

    // monitor / scoreboard
    logic [19:0] held;
    bit          in_rep = 1'b0;
    int          wait_n = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en && (rd_addr < 20'hC0000 || rd_addr >= 20'hE0000)) addr_bad++;
            if (found_valid) begin
                if (!in_rep) begin
                    in_rep = 1'b1;
                    held   = entry_addr;
                    wait_n = 0;
                    rep_cnt++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected report", entry_addr, 0);
                    end else begin
                        logic [19:0] e;
                        e = exp_q.pop_front();
                        check(entry_addr == e, "R5 entry address", entry_addr, e);
                    end
                end else if (entry_addr != held) begin
                    hold_bad++;
                end
                wait_n++;
                if (wait_n == 4) ack <= 1'b1;
            end else begin
                in_rep = 1'b0;
                ack <= 1'b0;
            end
            if (done) begin
                done_seen++;
                check(exp_q.size() == 0, "R1 reports left at done", exp_q.size(), 0);
                check(err_cnt == 8'(exp_err), "R4 sum failure count", err_cnt, exp_err);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", done_seen, 2);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // image table: base, span, header bytes, sum corruption
        ib[0] = 20'hC0000; isp[0] = 2048; h0[0] = 8'h55; h1[0] = 8'hAA; h2[0] = 8'd4; bump[0] = 0;
        ib[1] = 20'hC1000; isp[1] = 2560; h0[1] = 8'h55; h1[1] = 8'hAA; h2[1] = 8'd5; bump[1] = 0;
        ib[2] = 20'hC4000; isp[2] = 512;  h0[2] = 8'h55; h1[2] = 8'hAA; h2[2] = 8'd1; bump[2] = 1;
        ib[3] = 20'hC6000; isp[3] = 512;  h0[3] = 8'h55; h1[3] = 8'hAA; h2[3] = 8'd0; bump[3] = 0;
        ib[4] = 20'hC8000; isp[4] = 512;  h0[4] = 8'h55; h1[4] = 8'h00; h2[4] = 8'd1; bump[4] = 0;
        ib[5] = 20'hC8800; isp[5] = 512;  h0[5] = 8'hAA; h1[5] = 8'h55; h2[5] = 8'd1; bump[5] = 0;
        ib[6] = 20'hDF000; isp[6] = 2048; h0[6] = 8'h55; h1[6] = 8'hAA; h2[6] = 8'd4; bump[6] = 0;
        ib[7] = 20'hDF800; isp[7] = 2560; h0[7] = 8'h55; h1[7] = 8'hAA; h2[7] = 8'd5; bump[7] = 0;
        for (int i = 0; i < NIMG; i++) fx[i] = 8'h00;
        for (int i = 0; i < NIMG; i++) begin
            logic [7:0] s;
            s = 8'h00;
            for (int k = 0; k < isp[i] - 1; k++) s = s + mem_byte(ib[i] + 20'(k));
            fx[i] = 8'h00 - s + bump[i];
        end

        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(found_valid == 1'b0, "R9 found_valid in reset", found_valid, 0);
        check(done == 1'b0,        "R9 done in reset", done, 0);
        check(err_cnt == 8'd0,     "R9 err_cnt in reset", err_cnt, 0);
        check(rd_en == 1'b0,       "R9 rd_en in reset", rd_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_en == 1'b0 && found_valid == 1'b0, "R9 idle after reset", rd_en, 0);

        run_scan(1'b1);
        wait (done_seen == 1);
        repeat (20) @(negedge clk);
        check(rd_en == 1'b0,       "R1 no reads after done", rd_en, 0);
        check(found_valid == 1'b0, "R1 no report after done", found_valid, 0);
        check(err_cnt == 8'd1,     "R8 count held while idle", err_cnt, 1);

        run_scan(1'b0);
        wait (done_seen == 2);
        repeat (5) @(negedge clk);
        check(done_seen == 2, "R1 one done per scan", done_seen, 2);
        check(rep_cnt == 6,   "R6 report count over two scans", rep_cnt, 6);
        check(hold_bad == 0,  "R5 entry stable until ack", hold_bad, 0);
        check(addr_bad == 0,  "R7 reads inside window", addr_bad, 0);
        check(err_cnt == 8'd1, "R8 count cleared at restart", err_cnt, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule